// File: doc/BRIEF.md
# SEC-DED Code Memory Read Checker

This block sits between a code memory and the line-fill logic of an instruction cache. A fill request passes through to the memory. The block tracks that request's address until the memory answers. Each returned data word arrives with its stored check bits and is decoded with an extended Hamming code.

A clean word goes out unchanged. A word with one flipped bit goes out repaired and is marked as corrected. A word with two flipped bits goes out as read and is marked as bad. Repair applies only to the copy sent to the cache. Storage is never rewritten, so a faulty word is repaired again each time it is read.

The address of the latest corrected word and the address of the latest bad word are held in two separate log registers, which software reads through a small read port. Reading a log clears its valid and overflow bits. A level interrupt request stays high while an enabled log holds an unread event. The processor keeps running after the request.

Top module: `flash_secded_chk`

## Requirements
- R1: A response presented on `mem_rsp_valid` appears on `fill_rsp_valid` exactly one clock later. The data and both flags are registered in the same cycle, and no response appears without a memory response the cycle before.
- R2: The code has 7 Hamming bits and one overall bit for a 64-bit word. Data bit i sits at the i-th position, counting from 3, that is not a power of two. Check bit k (0..6) is the XOR of the data bits whose position has bit k set. Check bit 7 gives even parity over the other 71 bits. A word that matches its check bits is forwarded unchanged, with both flags low.
- R3: A single flipped data bit is restored in the forwarded word, and `fill_rsp_corrected` is high.
- R4: A single flipped check bit, including check bit 7, forwards the data unchanged with `fill_rsp_corrected` high and `fill_rsp_bad` low.
- R5: Two flipped bits anywhere in the 72-bit codeword forward the received data unmodified, with `fill_rsp_bad` high and `fill_rsp_corrected` low. The two flags are never high together.
- R6: Odd overall parity with a syndrome above 71, which no single-bit error can produce, is reported as bad, and the data is not modified.
- R7: Repair is not persistent. Reading the same faulty word again repairs it again and logs it again.
- R8: A corrected event stores its request address in the correction log and sets that log's valid bit. The log is read with `reg_rd_sel`=0.
- R9: A bad event stores its request address in the separate error log, read with `reg_rd_sel`=1. The correction log is left untouched.
- R10: `reg_rd_data` is {overflow, valid, address[ADDR_W-1:0]}, with the address in the low bits. A read strobe clears valid and overflow, and the address is kept. An event that arrives while valid is already set sets overflow and replaces the address.
- R11: `irq` is high while (correction log valid and `irq_en_corr`) or (error log valid and `irq_en_bad`). It stays high until the matching log is read.
- R12: Only one request is outstanding at a time. `fill_req_ready` is low from acceptance until the response arrives, and after reset it follows `mem_req_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fill_req_valid | input | 1 | Fill request from the cache |
| fill_req_ready | output | 1 | Request can be accepted |
| fill_req_addr | input | ADDR_W | Word address of the request |
| mem_req_valid | output | 1 | Request toward the memory |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | ADDR_W | Address toward the memory |
| mem_rsp_valid | input | 1 | Memory returns a word |
| mem_rsp_data | input | DATA_W | Returned data word |
| mem_rsp_chk | input | CHK_W | Returned check bits |
| fill_rsp_valid | output | 1 | Checked word valid toward the cache |
| fill_rsp_data | output | DATA_W | Checked (possibly repaired) word |
| fill_rsp_corrected | output | 1 | Word had a single-bit error that was repaired |
| fill_rsp_bad | output | 1 | Word has an uncorrectable error |
| reg_rd_en | input | 1 | Read strobe; clears the selected log |
| reg_rd_sel | input | 1 | 0 selects the correction log, 1 the error log |
| reg_rd_data | output | ADDR_W+2 | Selected log contents |
| irq_en_corr | input | 1 | Interrupt enable for corrected events |
| irq_en_bad | input | 1 | Interrupt enable for uncorrectable events |
| irq | output | 1 | Level interrupt request |

## Verification
The bench builds the block with DATA_W=64 and ADDR_W=16. A 64-bit word gives 7 Hamming bits, so syndromes 72 to 127 exist without any single-bit cause, and a triple flip of check bits 6, 3 and 0 reaches that corner. The 16-bit address keeps every logged value small enough to read at a glance. Each log record still carries both its valid and overflow bits above the address.

// File: rtl/flash_ecc_pkg.sv
package flash_ecc_pkg;

   typedef enum logic [1:0] {
      EV_CLEAN = 2'd0,
      EV_FIXED = 2'd1,
      EV_BAD   = 2'd2
   } ecc_ev_e;

   // Hamming bits needed for a data width (overall parity not counted)
   function automatic int ham_bits(input int dw);
      int r;
      r = 1;
      while ((1 << r) < dw + r + 1) r++;
      return r;
   endfunction

   // Codeword position of data bit idx: idx-th non power of two from 3
   function automatic int pos_of(input int idx);
      int n;
      n = 0;
      for (int q = 3; q < 8192; q++) begin
         if ((q & (q - 1)) != 0) begin
            if (n == idx) return q;
            n++;
         end
      end
      return 0;
   endfunction

endpackage

// File: rtl/flash_ecc_syndrome.sv
module flash_ecc_syndrome
   import flash_ecc_pkg::*;
#(
   parameter int DATA_W = 64,
   parameter int HAM_W  = 7
) (
   input  logic [DATA_W-1:0] data,
   input  logic [HAM_W:0]    chk,
   output logic [HAM_W-1:0]  syn,
   output ecc_ev_e           kind
);
   localparam logic [HAM_W:0] MAX_POS = (HAM_W+1)'(DATA_W + HAM_W);

   logic [HAM_W-1:0] contrib [DATA_W];
   logic             par_odd;

   for (genvar i = 0; i < DATA_W; i++) begin : g_pos
      localparam logic [HAM_W-1:0] P = HAM_W'(pos_of(i));
      assign contrib[i] = data[i] ? P : '0;
   end

   always_comb begin
      syn = chk[HAM_W-1:0];
      for (int i = 0; i < DATA_W; i++) syn = syn ^ contrib[i];
   end

   assign par_odd = ^{data, chk};

   always_comb begin
      if (!par_odd) kind = (syn == '0) ? EV_CLEAN : EV_BAD;
      else if ({1'b0, syn} > MAX_POS) kind = EV_BAD;
      else kind = EV_FIXED;
   end
endmodule

// File: rtl/flash_ecc_fix.sv
module flash_ecc_fix
   import flash_ecc_pkg::*;
#(
   parameter int DATA_W = 64,
   parameter int HAM_W  = 7
) (
   input  logic [DATA_W-1:0] data,
   input  logic [HAM_W-1:0]  syn,
   input  logic              fix_en,
   output logic [DATA_W-1:0] fixed
);
   logic [DATA_W-1:0] flip;

   for (genvar i = 0; i < DATA_W; i++) begin : g_flip
      localparam logic [HAM_W-1:0] P = HAM_W'(pos_of(i));
      assign flip[i] = fix_en && (syn == P);
   end

   assign fixed = data ^ flip;
endmodule

// File: rtl/flash_ecc_log.sv
module flash_ecc_log #(
   parameter int ADDR_W = 24
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hit,
   input  logic [ADDR_W-1:0] hit_addr,
   input  logic              clr,
   output logic              valid,
   output logic              ovf,
   output logic [ADDR_W-1:0] addr
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid <= 1'b0;
         ovf   <= 1'b0;
         addr  <= '0;
      end else if (hit) begin
         addr  <= hit_addr;
         valid <= 1'b1;
         ovf   <= clr ? 1'b0 : (ovf | valid);
      end else if (clr) begin
         valid <= 1'b0;
         ovf   <= 1'b0;
      end
   end
endmodule

// File: rtl/flash_secded_chk.sv
module flash_secded_chk
   import flash_ecc_pkg::*;
#(
   parameter int   DATA_W = 64,
   parameter int   ADDR_W = 24,
   localparam int  HAM_W  = ham_bits(DATA_W),
   localparam int  CHK_W  = HAM_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fill_req_valid,
   output logic              fill_req_ready,
   input  logic [ADDR_W-1:0] fill_req_addr,
   output logic              mem_req_valid,
   input  logic              mem_req_ready,
   output logic [ADDR_W-1:0] mem_req_addr,
   input  logic              mem_rsp_valid,
   input  logic [DATA_W-1:0] mem_rsp_data,
   input  logic [CHK_W-1:0]  mem_rsp_chk,
   output logic              fill_rsp_valid,
   output logic [DATA_W-1:0] fill_rsp_data,
   output logic              fill_rsp_corrected,
   output logic              fill_rsp_bad,
   input  logic              reg_rd_en,
   input  logic              reg_rd_sel,
   output logic [ADDR_W+1:0] reg_rd_data,
   input  logic              irq_en_corr,
   input  logic              irq_en_bad,
   output logic              irq
);
   if (DATA_W < 4) begin : g_bad_data_w
      $error("DATA_W must be at least 4");
   end
   if (ADDR_W < 1) begin : g_bad_addr_w
      $error("ADDR_W must be at least 1");
   end

   logic              busy;
   logic [ADDR_W-1:0] pend_addr;
   logic              accept;
   logic [HAM_W-1:0]  syn;
   ecc_ev_e           kind;
   logic [DATA_W-1:0] fixed;
   logic              corr_valid, corr_ovf, bad_valid, bad_ovf;
   logic [ADDR_W-1:0] corr_addr, bad_addr;

   assign mem_req_valid  = fill_req_valid & ~busy;
   assign mem_req_addr   = fill_req_addr;
   assign fill_req_ready = mem_req_ready & ~busy;
   assign accept         = mem_req_valid & mem_req_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy      <= 1'b0;
         pend_addr <= '0;
      end else if (accept) begin
         busy      <= 1'b1;
         pend_addr <= fill_req_addr;
      end else if (mem_rsp_valid) begin
         busy      <= 1'b0;
      end
   end

   flash_ecc_syndrome #(.DATA_W(DATA_W), .HAM_W(HAM_W)) u_syn (
      .data (mem_rsp_data),
      .chk  (mem_rsp_chk),
      .syn  (syn),
      .kind (kind)
   );

   flash_ecc_fix #(.DATA_W(DATA_W), .HAM_W(HAM_W)) u_fix (
      .data   (mem_rsp_data),
      .syn    (syn),
      .fix_en (kind == EV_FIXED),
      .fixed  (fixed)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fill_rsp_valid     <= 1'b0;
         fill_rsp_data      <= '0;
         fill_rsp_corrected <= 1'b0;
         fill_rsp_bad       <= 1'b0;
      end else begin
         fill_rsp_valid     <= mem_rsp_valid;
         fill_rsp_corrected <= mem_rsp_valid && (kind == EV_FIXED);
         fill_rsp_bad       <= mem_rsp_valid && (kind == EV_BAD);
         if (mem_rsp_valid) fill_rsp_data <= fixed;
      end
   end

   flash_ecc_log #(.ADDR_W(ADDR_W)) u_corr_log (
      .clk      (clk),
      .rst_n    (rst_n),
      .hit      (mem_rsp_valid && (kind == EV_FIXED)),
      .hit_addr (pend_addr),
      .clr      (reg_rd_en && !reg_rd_sel),
      .valid    (corr_valid),
      .ovf      (corr_ovf),
      .addr     (corr_addr)
   );

   flash_ecc_log #(.ADDR_W(ADDR_W)) u_bad_log (
      .clk      (clk),
      .rst_n    (rst_n),
      .hit      (mem_rsp_valid && (kind == EV_BAD)),
      .hit_addr (pend_addr),
      .clr      (reg_rd_en && reg_rd_sel),
      .valid    (bad_valid),
      .ovf      (bad_ovf),
      .addr     (bad_addr)
   );

   assign reg_rd_data = reg_rd_sel ? {bad_ovf, bad_valid, bad_addr}
                                   : {corr_ovf, corr_valid, corr_addr};
   assign irq = (corr_valid & irq_en_corr) | (bad_valid & irq_en_bad);
endmodule

// File: rtl/flash_secded_chk_sva.sv
module flash_secded_chk_sva (
   input logic clk,
   input logic rst_n,
   input logic mem_req_valid,
   input logic mem_req_ready,
   input logic fill_req_ready,
   input logic mem_rsp_valid,
   input logic fill_rsp_valid,
   input logic fill_rsp_corrected,
   input logic fill_rsp_bad,
   input logic reg_rd_en,
   input logic irq_en_corr,
   input logic irq_en_bad,
   input logic irq,
   input logic corr_valid,
   input logic bad_valid
);
   // R1
   rsp_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rsp_valid |=> fill_rsp_valid);
   // R1
   rsp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_rsp_valid |=> !fill_rsp_valid);
   // R5
   flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(fill_rsp_corrected && fill_rsp_bad));
   // R3
   flag_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_rsp_corrected || fill_rsp_bad) |-> fill_rsp_valid);
   // R8
   corr_log_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fill_rsp_corrected |-> corr_valid);
   // R9
   bad_log_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fill_rsp_bad |-> bad_valid);
   // R12
   one_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && mem_req_ready) |=> !fill_req_ready);
   // R11
   irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !reg_rd_en) |=> (irq || !irq_en_corr || !irq_en_bad));
endmodule

bind flash_secded_chk flash_secded_chk_sva u_sva (
   .clk                (clk),
   .rst_n              (rst_n),
   .mem_req_valid      (mem_req_valid),
   .mem_req_ready      (mem_req_ready),
   .fill_req_ready     (fill_req_ready),
   .mem_rsp_valid      (mem_rsp_valid),
   .fill_rsp_valid     (fill_rsp_valid),
   .fill_rsp_corrected (fill_rsp_corrected),
   .fill_rsp_bad       (fill_rsp_bad),
   .reg_rd_en          (reg_rd_en),
   .irq_en_corr        (irq_en_corr),
   .irq_en_bad         (irq_en_bad),
   .irq                (irq),
   .corr_valid         (corr_valid),
   .bad_valid          (bad_valid)
);

// File: tb/flash_secded_chk_bench.sv
module flash_secded_chk_bench;
   localparam int DW = 64;
   localparam int AW = 16;
   localparam int NV = 10;

   // {flip0, flip1, flip2, kind}; 255 = no flip; kind 0 clean, 1 fixed, 2 bad
   localparam logic [25:0] VEC [NV] = '{
      {8'd255, 8'd255, 8'd255, 2'd0},
      {8'd0,   8'd255, 8'd255, 2'd1},
      {8'd63,  8'd255, 8'd255, 2'd1},
      {8'd64,  8'd255, 8'd255, 2'd1},
      {8'd71,  8'd255, 8'd255, 2'd1},
      {8'd70,  8'd255, 8'd255, 2'd1},
      {8'd5,   8'd40,  8'd255, 2'd2},
      {8'd0,   8'd71,  8'd255, 2'd2},
      {8'd64,  8'd65,  8'd255, 2'd2},
      {8'd70,  8'd67,  8'd64,  2'd2}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          fill_req_valid = 1'b0;
   logic          fill_req_ready;
   logic [AW-1:0] fill_req_addr = '0;
   logic          mem_req_valid;
   logic          mem_req_ready = 1'b1;
   logic [AW-1:0] mem_req_addr;
   logic          mem_rsp_valid = 1'b0;
   logic [DW-1:0] mem_rsp_data = '0;
   logic [7:0]    mem_rsp_chk = '0;
   logic          fill_rsp_valid;
   logic [DW-1:0] fill_rsp_data;
   logic          fill_rsp_corrected;
   logic          fill_rsp_bad;
   logic          reg_rd_en = 1'b0;
   logic          reg_rd_sel = 1'b0;
   logic [AW+1:0] reg_rd_data;
   logic          irq_en_corr = 1'b1;
   logic          irq_en_bad = 1'b1;
   logic          irq;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   flash_secded_chk #(.DATA_W(DW), .ADDR_W(AW)) u_flash_secded_chk (.*);

   task automatic check(input string tag, input logic [71:0] act, input logic [71:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %0h expected %0h", tag, act, exp);
      end
   endtask

   function automatic logic [7:0] enc(input logic [DW-1:0] d);
      logic [7:0] c;
      int di;
      c = '0;
      di = 0;
      for (int p = 1; p < 72; p++) begin
         if ((p & (p - 1)) != 0) begin
            if (d[di]) c[6:0] = c[6:0] ^ 7'(p);
            di++;
         end
      end
      c[7] = ^d ^ ^c[6:0];
      return c;
   endfunction

   function automatic logic [71:0] corrupt(input logic [71:0] cw, input logic [25:0] v);
      logic [71:0] r;
      r = cw;
      if (v[25:18] != 8'd255) r[v[25:18]] = ~r[v[25:18]];
      if (v[17:10] != 8'd255) r[v[17:10]] = ~r[v[17:10]];
      if (v[9:2]   != 8'd255) r[v[9:2]]   = ~r[v[9:2]];
      return r;
   endfunction

   // one full read; called and returns at a negedge
   task automatic do_read(input logic [AW-1:0] a, input logic [71:0] cw,
                          input logic [DW-1:0] exp_d, input logic [1:0] kind,
                          input string tag);
      fill_req_valid = 1'b1;
      fill_req_addr  = a;
      #1 check("R12 ready idle", {71'd0, fill_req_ready}, 72'd1);
      @(posedge clk);
      @(negedge clk);
      fill_req_valid = 1'b0;
      check("R12 ready busy", {71'd0, fill_req_ready}, 72'd0);
      mem_rsp_valid = 1'b1;
      mem_rsp_data  = cw[63:0];
      mem_rsp_chk   = cw[71:64];
      #1 check("R1 not early", {71'd0, fill_rsp_valid}, 72'd0);
      @(posedge clk);
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      check({"R1 valid ", tag}, {71'd0, fill_rsp_valid}, 72'd1);
      check({tag, " data"}, {8'd0, fill_rsp_data}, {8'd0, exp_d});
      check({tag, " corrected"}, {71'd0, fill_rsp_corrected}, {71'd0, kind == 2'd1});
      check({tag, " bad"}, {71'd0, fill_rsp_bad}, {71'd0, kind == 2'd2});
   endtask

   // read a log (clearing it), then show cleared state; called at a negedge
   task automatic rd_log(input logic sel, input logic [AW+1:0] exp, input string tag);
      reg_rd_sel = sel;
      reg_rd_en  = 1'b1;
      #1 check(tag, {{(70-AW){1'b0}}, reg_rd_data}, {{(70-AW){1'b0}}, exp});
      @(posedge clk);
      @(negedge clk);
      reg_rd_en = 1'b0;
      #1 check("R10 cleared", {{(70-AW){1'b0}}, reg_rd_data},
               {{(70-AW){1'b0}}, 2'b00, exp[AW-1:0]});
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual hung expected finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [DW-1:0] d;
      logic [71:0]   cw, bad;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // reset state
      check("R1 reset valid", {71'd0, fill_rsp_valid}, 72'd0);
      check("R11 reset irq", {71'd0, irq}, 72'd0);
      check("R12 reset ready", {71'd0, fill_req_ready}, 72'd1);
      reg_rd_sel = 1'b0;
      #1 check("R8 reset log", {{(70-AW){1'b0}}, reg_rd_data}, 72'd0);
      reg_rd_sel = 1'b1;
      #1 check("R9 reset log", {{(70-AW){1'b0}}, reg_rd_data}, 72'd0);
      @(negedge clk);

      // table: R2 clean, R3/R4 single, R5 double, R6 out-of-range syndrome
      for (int i = 0; i < NV; i++) begin
         d   = 64'h0123_4567_89AB_CDEF ^ {8{8'(i * 53)}};
         cw  = {enc(d), d};
         bad = corrupt(cw, VEC[i]);
         do_read(AW'(16'h0100 + i), bad, (VEC[i][1:0] == 2'd2) ? bad[63:0] : d,
                 VEC[i][1:0], $sformatf("R%0d vec%0d",
                 (i == 0) ? 2 : (i < 3) ? 3 : (i < 6) ? 4 : (i < 9) ? 5 : 6, i));
      end

      // R11 irq pending, then per-log clearing (R8, R9, R10)
      check("R11 irq after events", {71'd0, irq}, 72'd1);
      rd_log(1'b0, {2'b11, 16'h0105}, "R8 corr log");
      check("R11 irq bad pending", {71'd0, irq}, 72'd1);
      rd_log(1'b1, {2'b11, 16'h0109}, "R9 bad log");
      check("R11 irq cleared", {71'd0, irq}, 72'd0);

      // R7: same faulty word read twice, repaired each time
      d  = 64'hFFFF_FFFF_FFFF_FFFF;
      cw = {enc(d), d};
      cw[17] = ~cw[17];
      do_read(16'h02AA, cw, d, 2'd1, "R7 first");
      do_read(16'h02AA, cw, d, 2'd1, "R7 second");
      rd_log(1'b0, {2'b11, 16'h02AA}, "R7 relogged");
      // R9: bad log untouched by corrected events
      reg_rd_sel = 1'b1;
      #1 check("R9 untouched", {{(70-AW){1'b0}}, reg_rd_data}, {54'd0, 2'b00, 16'h0109});
      @(negedge clk);

      // R11 enable gating and level hold
      irq_en_corr = 1'b0;
      d  = 64'd0;
      cw = {enc(d), d};
      cw[66] = ~cw[66];
      do_read(16'h0033, cw, d, 2'd1, "R4 zero word");
      check("R11 gated", {71'd0, irq}, 72'd0);
      irq_en_corr = 1'b1;
      #1 check("R11 enabled", {71'd0, irq}, 72'd1);
      repeat (3) @(negedge clk);
      check("R11 level hold", {71'd0, irq}, 72'd1);
      rd_log(1'b0, {2'b01, 16'h0033}, "R10 single event");
      check("R11 low after read", {71'd0, irq}, 72'd0);

      irq_en_bad = 1'b0;
      cw = {enc(d), d};
      cw[2] = ~cw[2];
      cw[9] = ~cw[9];
      do_read(16'h0044, cw, cw[63:0], 2'd2, "R5 zero word");
      check("R11 bad gated", {71'd0, irq}, 72'd0);
      rd_log(1'b1, {2'b01, 16'h0044}, "R9 new bad addr");

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule